// File: doc/BRIEF.md
# Context-Tagged Branch Direction Predictor

This block predicts whether a conditional branch is taken, using a table of 2-bit saturating counters selected by fetch-address bits. The table is split into groups of counters, and each group remembers the address-space identifier and privilege level that last trained it. A lookup may use a counter only when both tags match the requester's identifier and privilege. In every other case it answers "not taken" and flags a miss, so fetch simply continues sequentially and never follows training left by another context.

Resolved branch outcomes train the table through an update port. An update that reaches a group owned by another context first reclaims that group. All its counters return to weakly not-taken, the new owner's tags are stored, and only then is the outcome applied. A purge command walks the table one group per cycle and wipes every group owned by user mode, while supervisor-mode training survives.

The lookup request has no back-pressure (its ready is tied high), and the response appears exactly one cycle later with no ready, so the consumer must take it. The update stream is back-pressured: `upd_ready` is low while a purge walk is in progress, and an update is accepted only in a cycle where `upd_valid` and `upd_ready` are both high. The index inputs carry the fetch address with the instruction-alignment bits already dropped, and only the low index bits are presented.

Top module: `ctx_tagged_bpred`

## Requirements
- R1: After reset every group is unowned. A lookup then gives `pred_hit`=0 and `pred_taken`=0, `pred_valid` is 0 and `upd_ready` is 1 until the first request, and `purge_busy` is 0.
- R2: `pred_valid` is high in the cycle after a cycle with `lk_valid` high, and low otherwise. The lookup has one cycle of latency.
- R3: Counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. The prediction on a hit is bit 1. An update adds one when taken and subtracts one when not taken, saturating at 00 and 11.
- R4: A lookup whose identifier differs from the identifier stored for the indexed group gives `pred_hit`=0 and `pred_taken`=0.
- R5: A lookup whose privilege (`lk_priv`: 0 = user, 1 = supervisor) differs from the group's stored privilege gives `pred_hit`=0 and `pred_taken`=0.
- R6: An update to a group that is unowned or owned by another identifier or privilege first sets every counter of that group to 01. It then stores the update's identifier and privilege, and finally applies the outcome to the addressed counter.
- R7: A purge clears the ownership of every user-owned group and resets its counters to 01. Supervisor-owned groups keep their tags and counters.
- R8: A purge request accepted while idle raises `purge_busy` from the next cycle for exactly NUM_GROUPS cycles. During that time `upd_ready` is 0 and lookups miss.
- R9: When an update and a lookup reach the same counter in the same cycle, the lookup reports the value from before the update.
- R10: Each group of GROUP_CTRS consecutive indices has its own tags. Claiming one group leaves the ownership and counters of the other groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready, always 1 |
| lk_idx | input | IDX_W | Fetch address bits above alignment, low IDX_W bits |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_priv | input | 1 | Current privilege, 0 user, 1 supervisor |
| pred_valid | output | 1 | Lookup response valid |
| pred_hit | output | 1 | Tags matched and prediction is trained |
| pred_taken | output | 1 | Predicted direction, 0 on a miss |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update accepted when high with upd_valid |
| upd_idx | input | IDX_W | Index of the resolved branch |
| upd_asid | input | ASID_W | Identifier of the resolving context |
| upd_priv | input | 1 | Privilege of the resolving context |
| upd_taken | input | 1 | Resolved outcome |
| purge_req | input | 1 | Start a purge of user-owned groups |
| purge_busy | output | 1 | Purge walk in progress |

## Verification
The bench trains a counter through every state and probes both saturation ends. A design whose counters wrap around would flip its prediction after repeated not-taken outcomes. It checks a neighbour counter after a group is claimed, because a design that skips the reinitialisation would carry stale training into the new context. It purges a table that holds one user group and one supervisor group: a purge that ignores privilege would lose supervisor training, and one that lets lookups hit during the walk would leak stale predictions. It also issues an update and a lookup to one counter in the same cycle, which exposes a design that forwards the new value.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam logic PRIV_USER = 1'b0;
  localparam logic PRIV_SUP  = 1'b1;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'b11) ? 2'b11 : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? 2'b00 : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/ctp_counter_array.sv
module ctp_counter_array #(
  parameter int NUM_CTRS   = 1024,
  parameter int GROUP_CTRS = 256,
  localparam int IDX_W      = $clog2(NUM_CTRS),
  localparam int NUM_GROUPS = NUM_CTRS / GROUP_CTRS,
  localparam int GRP_W      = $clog2(NUM_GROUPS),
  localparam int OFF_W      = $clog2(GROUP_CTRS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [1:0]       rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [1:0]       rd_b_val,
  input  logic             clr_en,
  input  logic [GRP_W-1:0] clr_grp,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_val
);
  logic [1:0] grp_rd_a [NUM_GROUPS];
  logic [1:0] grp_rd_b [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [1:0] mem [GROUP_CTRS];
    always_ff @(posedge clk) begin
      for (int j = 0; j < GROUP_CTRS; j++) begin
        if (rst || (clr_en && clr_grp == GRP_W'(g)))
          mem[j] <= ctp_pkg::CTR_WNT;
        if (!rst && wr_en && wr_idx == IDX_W'(g * GROUP_CTRS + j))
          mem[j] <= wr_val;
      end
    end
    assign grp_rd_a[g] = mem[rd_a_idx[OFF_W-1:0]];
    assign grp_rd_b[g] = mem[rd_b_idx[OFF_W-1:0]];
  end

  assign rd_a_val = grp_rd_a[rd_a_idx[IDX_W-1:OFF_W]];
  assign rd_b_val = grp_rd_b[rd_b_idx[IDX_W-1:OFF_W]];
endmodule

// File: rtl/ctp_tag_store.sv
module ctp_tag_store #(
  parameter int NUM_GROUPS = 4,
  parameter int ASID_W     = 12,
  localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_W-1:0]  lk_grp,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_priv,
  output logic              lk_match,
  input  logic [GRP_W-1:0]  upd_grp,
  input  logic [ASID_W-1:0] upd_asid,
  input  logic              upd_priv,
  output logic              upd_match,
  input  logic              claim_en,
  input  logic [GRP_W-1:0]  walk_grp,
  output logic              walk_user,
  input  logic              drop_en
);
  logic [ASID_W-1:0] tag_asid [NUM_GROUPS];
  logic              tag_priv [NUM_GROUPS];
  logic              tag_vld  [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_vld[g]  <= 1'b0;
        tag_asid[g] <= '0;
        tag_priv[g] <= ctp_pkg::PRIV_USER;
      end else if (claim_en && upd_grp == GRP_W'(g)) begin
        tag_vld[g]  <= 1'b1;
        tag_asid[g] <= upd_asid;
        tag_priv[g] <= upd_priv;
      end else if (drop_en && walk_grp == GRP_W'(g)) begin
        tag_vld[g]  <= 1'b0;
      end
    end
  end

  assign lk_match  = tag_vld[lk_grp] && tag_asid[lk_grp] == lk_asid
                     && tag_priv[lk_grp] == lk_priv;
  assign upd_match = tag_vld[upd_grp] && tag_asid[upd_grp] == upd_asid
                     && tag_priv[upd_grp] == upd_priv;
  assign walk_user = tag_vld[walk_grp] && tag_priv[walk_grp] == ctp_pkg::PRIV_USER;
endmodule

// File: rtl/ctp_purge_walker.sv
module ctp_purge_walker #(
  parameter int NUM_GROUPS = 4,
  localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [GRP_W-1:0] grp
);
  localparam logic [GRP_W-1:0] LAST = GRP_W'(NUM_GROUPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      grp  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        grp  <= '0;
      end
    end else begin
      if (grp == LAST) busy <= 1'b0;
      grp <= grp + 1'b1;
    end
  end
endmodule

// File: rtl/ctx_tagged_bpred.sv
module ctx_tagged_bpred #(
  parameter int NUM_CTRS   = 1024,
  parameter int GROUP_CTRS = 256,
  parameter int ASID_W     = 12,
  localparam int IDX_W      = $clog2(NUM_CTRS),
  localparam int NUM_GROUPS = NUM_CTRS / GROUP_CTRS,
  localparam int GRP_W      = $clog2(NUM_GROUPS),
  localparam int OFF_W      = $clog2(GROUP_CTRS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_priv,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [ASID_W-1:0] upd_asid,
  input  logic              upd_priv,
  input  logic              upd_taken,
  input  logic              purge_req,
  output logic              purge_busy
);
  logic             lk_match, upd_match, walk_user;
  logic [GRP_W-1:0] walk_grp;
  logic [1:0]       lk_ctr, upd_ctr, upd_new;
  logic             upd_fire, reclaim, drop;
  logic             clr_en;
  logic [GRP_W-1:0] clr_grp;

  assign lk_ready  = 1'b1;
  assign upd_ready = !purge_busy;
  assign upd_fire  = upd_valid && upd_ready;
  assign reclaim   = upd_fire && !upd_match;
  assign drop      = purge_busy && walk_user;
  assign clr_en    = reclaim || drop;
  assign clr_grp   = reclaim ? upd_idx[IDX_W-1:OFF_W] : walk_grp;
  assign upd_new   = ctp_pkg::ctr_step(upd_match ? upd_ctr : ctp_pkg::CTR_WNT, upd_taken);

  ctp_purge_walker #(.NUM_GROUPS(NUM_GROUPS)) u_walk (
    .clk(clk), .rst(rst), .start(purge_req), .busy(purge_busy), .grp(walk_grp)
  );

  ctp_tag_store #(.NUM_GROUPS(NUM_GROUPS), .ASID_W(ASID_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_grp(lk_idx[IDX_W-1:OFF_W]), .lk_asid(lk_asid), .lk_priv(lk_priv),
    .lk_match(lk_match),
    .upd_grp(upd_idx[IDX_W-1:OFF_W]), .upd_asid(upd_asid), .upd_priv(upd_priv),
    .upd_match(upd_match),
    .claim_en(upd_fire), .walk_grp(walk_grp), .walk_user(walk_user), .drop_en(drop)
  );

  ctp_counter_array #(.NUM_CTRS(NUM_CTRS), .GROUP_CTRS(GROUP_CTRS)) u_ctrs (
    .clk(clk), .rst(rst),
    .rd_a_idx(lk_idx), .rd_a_val(lk_ctr),
    .rd_b_idx(upd_idx), .rd_b_val(upd_ctr),
    .clr_en(clr_en), .clr_grp(clr_grp),
    .wr_en(upd_fire), .wr_idx(upd_idx), .wr_val(upd_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      pred_hit   <= lk_valid && lk_match && !purge_busy;
      pred_taken <= lk_valid && lk_match && !purge_busy && lk_ctr[1];
    end
  end
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
  parameter int NUM_GROUPS = 4
) (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic pred_valid,
  input logic pred_hit,
  input logic pred_taken,
  input logic upd_ready,
  input logic purge_req,
  input logic purge_busy
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst || !purge_busy) busy_run <= 0;
    else                    busy_run <= busy_run + 1;
  end

  a_r2_resp_after_req: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);
  a_r2_no_resp_without_req: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);
  a_r4_miss_predicts_not_taken: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> !pred_taken);
  a_r1_hit_needs_request: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);
  a_r8_no_hit_during_walk: assert property (@(posedge clk) disable iff (rst)
    (purge_busy && $past(purge_busy)) |-> !pred_hit);
  a_r8_updates_stalled: assert property (@(posedge clk) disable iff (rst)
    purge_busy |-> !upd_ready);
  a_r8_walk_starts_on_request: assert property (@(posedge clk) disable iff (rst)
    $rose(purge_busy) |-> $past(purge_req));
  a_r8_walk_length: assert property (@(posedge clk) disable iff (rst)
    busy_run <= NUM_GROUPS);
endmodule

bind ctx_tagged_bpred ctp_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .pred_valid(pred_valid),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .upd_ready(upd_ready),
  .purge_req(purge_req), .purge_busy(purge_busy)
);

// File: tb/tb_ctx_tagged_bpred.sv
module tb_ctx_tagged_bpred;
  localparam int NUM_CTRS = 1024, GROUP_CTRS = 256, ASID_W = 12;
  localparam int IDX_W = $clog2(NUM_CTRS);
  localparam int NUM_GROUPS = NUM_CTRS / GROUP_CTRS;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, lk_priv = 0, upd_valid = 0, upd_priv = 0, upd_taken = 0, purge_req = 0;
  logic [IDX_W-1:0] lk_idx = '0, upd_idx = '0;
  logic [ASID_W-1:0] lk_asid = '0, upd_asid = '0;
  logic lk_ready, pred_valid, pred_hit, pred_taken, upd_ready, purge_busy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ctx_tagged_bpred #(.NUM_CTRS(NUM_CTRS), .GROUP_CTRS(GROUP_CTRS), .ASID_W(ASID_W)) dut (.*);

  typedef struct packed {
    logic        is_upd;
    logic [9:0]  idx;
    logic [11:0] asid;
    logic        priv;
    logic        tkn;
    logic        ehit;
    logic        etkn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 unowned miss
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // claim, ctr 10
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 taken after claim
    '{1'b0, 10'd5,   12'd5, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 neighbour at 01
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // 11
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // 10
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // 01
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // 00
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // stays 00
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // 01
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 saturated low
    '{1'b1, 10'd4,   12'd5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // 10
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
    '{1'b0, 10'd4,   12'd6, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 other asid
    '{1'b0, 10'd4,   12'd5, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 other priv
    '{1'b1, 10'd260, 12'd9, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10}, // claim group 1 sup
    '{1'b0, 10'd260, 12'd9, 1'b1, 1'b0, 1'b1, 1'b1, 4'd10}, // R10
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 group 0 kept
    '{1'b1, 10'd5,   12'd7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // reclaim group 0
    '{1'b0, 10'd4,   12'd7, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 old 10 reset to 01
    '{1'b0, 10'd4,   12'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 old owner misses
    '{1'b1, 10'd4,   12'd7, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // 10
    '{1'b0, 10'd4,   12'd7, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6}   // R6
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [9:0] idx, input logic [11:0] asid, input logic priv,
                           output logic hit, output logic tkn);
    lk_valid = 1; lk_idx = idx; lk_asid = asid; lk_priv = priv;
    @(negedge clk);
    lk_valid = 0;
    hit = pred_hit; tkn = pred_taken;
    chk("R2 pred_valid", {7'd0, pred_valid}, 8'd1);
  endtask

  task automatic do_update(input logic [9:0] idx, input logic [11:0] asid, input logic priv,
                           input logic tkn);
    upd_valid = 1; upd_idx = idx; upd_asid = asid; upd_priv = priv; upd_taken = tkn;
    @(negedge clk);
    upd_valid = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic h, t;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pred_valid", {7'd0, pred_valid}, 8'd0);
    chk("R1 upd_ready", {7'd0, upd_ready}, 8'd1);
    chk("R1 purge_busy", {7'd0, purge_busy}, 8'd0);
    chk("R2 lk_ready", {7'd0, lk_ready}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_upd) begin
        do_update(VECS[i].idx, VECS[i].asid, VECS[i].priv, VECS[i].tkn);
      end else begin
        do_lookup(VECS[i].idx, VECS[i].asid, VECS[i].priv, h, t);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), {6'd0, h, t},
            {6'd0, VECS[i].ehit, VECS[i].etkn});
      end
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    chk("R2 idle", {7'd0, pred_valid}, 8'd0);

    // R8 / R7: purge with group 0 user-owned (asid 7) and group 1 supervisor (asid 9)
    purge_req = 1;
    @(negedge clk);
    purge_req = 0;
    chk("R8 busy first", {7'd0, purge_busy}, 8'd1);
    chk("R8 upd_ready low", {7'd0, upd_ready}, 8'd0);
    do_lookup(10'd260, 12'd9, 1'b1, h, t);
    chk("R8 lookup misses while busy", {6'd0, h, t}, 8'd0);
    for (int k = 1; k < NUM_GROUPS; k++) begin
      if (k > 1) @(negedge clk);
      chk("R8 busy held", {7'd0, purge_busy}, 8'd1);
    end
    @(negedge clk);
    chk("R8 busy ends", {7'd0, purge_busy}, 8'd0);
    chk("R8 upd_ready back", {7'd0, upd_ready}, 8'd1);
    do_lookup(10'd4, 12'd7, 1'b0, h, t);
    chk("R7 user group purged", {6'd0, h, t}, 8'd0);
    do_lookup(10'd260, 12'd9, 1'b1, h, t);
    chk("R7 supervisor group kept", {6'd0, h, t}, 8'd3);

    // R9: same-cycle update (not taken, 10 -> 01) and lookup
    upd_valid = 1; upd_idx = 10'd260; upd_asid = 12'd9; upd_priv = 1; upd_taken = 0;
    do_lookup(10'd260, 12'd9, 1'b1, h, t);
    upd_valid = 0;
    chk("R9 pre-update value", {6'd0, h, t}, 8'd3);
    do_lookup(10'd260, 12'd9, 1'b1, h, t);
    chk("R9 update applied", {6'd0, h, t}, 8'd2);

    // R1: reset again clears ownership
    rst = 1;
    @(negedge clk);
    rst = 0;
    do_lookup(10'd260, 12'd9, 1'b1, h, t);
    chk("R1 miss after reset", {6'd0, h, t}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule